// File: doc/BRIEF.md
# DMA Channel Register File for a Bus-Master Storage Adapter

This block holds the DMA control and status state of one bus-master channel in a storage adapter. A host port reads and writes eight 32-bit word registers: command, start count, start address, working count, working address, status, start list pointer and working list pointer. Writing a start action to the command register arms a transfer. The start values are copied into the working registers, the status is wiped and the run flag is raised.

A transfer engine outside this block asks for byte-length chunks in one of two directions. The block accepts a chunk only when its direction matches the direction bit of the command register. It clips the chunk to the bytes that remain, counts the working count down and the working address up, and flags done when nothing remains. Completion of a request on the storage-bus side also forces the count to zero and sets done.

The status register reports the storage core's interrupt line live. An external mode input chooses how the sticky error, abort and done bits are cleared: either by writing ones to them, or as a side effect of reading the status register.

Top module: `dmachan_regs`

## Requirements
- R1: After reset the registers read as follows: command, both start registers, working count and status all read 0, working address reads 0xFFFFFFFF, working list pointer reads 0xFFFFFFFD, and `dma_run` and `abort_req` are low.
- R2: Word indices are 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start list pointer and 7 working list pointer. Indices 0, 1, 2 and 6 store the written word, which reads back from the next cycle. Host writes to indices 3, 4 and 7 leave those registers unchanged.
- R3: Command bits [1:0] pick the action: 0 idle, 1 blast, 2 abort, 3 start. A start copies index 1 to 3, index 2 to 4 and index 6 to 7, clears status bits [5:0] and sets `dma_run` from the next cycle. Idle clears `dma_run`.
- R4: An abort write raises `abort_req` for exactly the one cycle after the write, and `dma_run` keeps its value. A blast write only stores the command word.
- R5: A chunk is accepted (`chunk_ack`) when `chunk_to_mem` equals command bit 7 (1 means device to memory). The granted length is the smaller of `chunk_len` and the working count. At the next edge the working count drops by the grant and the working address rises by it.
- R6: When an accepted chunk brings the working count to zero, status bit 3 (done) is set.
- R7: A chunk whose direction differs from command bit 7 gets `chunk_ack` low and a grant of 0, and leaves the working count and working address unchanged.
- R8: With `st_w1c_mode` high, a write to status clears bits 1 (error), 2 (abort) and 3 (done) where the written data has ones. Other status bits are unaffected, and reading status does not clear it.
- R9: With `st_w1c_mode` low, host writes to the status register have no effect.
- R10: With `st_w1c_mode` low, a status read returns the current value and then clears bits 1, 2 and 3.
- R11: A status read returns bit 4 set whenever `core_irq` is high.
- R12: A `req_complete` pulse sets the working count to 0 and sets done at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (triggers read-to-clear) |
| host_idx | input | 3 | Register word index |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Read data for `host_idx`, combinational |
| st_w1c_mode | input | 1 | 1: status clears on write-one, 0: status clears on read |
| core_irq | input | 1 | Interrupt line from the storage protocol core |
| chunk_req | input | 1 | Transfer engine presents a chunk |
| chunk_to_mem | input | 1 | Chunk direction, 1 = device to memory |
| chunk_len | input | LW | Requested chunk length in bytes |
| chunk_ack | output | 1 | Chunk accepted |
| chunk_grant | output | LW | Granted bytes, 0 when not accepted |
| req_complete | input | 1 | Storage-side request completion pulse |
| dma_run | output | 1 | DMA enabled |
| abort_req | output | 1 | One-cycle request to cancel the current request |

## Verification
The assertions assume one host operation per cycle. They also assume that a chunk request, a completion pulse and a start write do not all land in the same cycle. Where they could collide, each property names the quiet inputs in its antecedent, so it only claims the isolated case. The stimulus issues every host access, chunk and completion as its own single-cycle event followed by an idle cycle. The mode input and `core_irq` change only between operations, so every property's antecedent is met cleanly.

// File: rtl/dmachan_pkg.sv
package dmachan_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_BLAST = 2'd1,
    ACT_ABORT = 2'd2,
    ACT_START = 2'd3
  } dma_act_e;

  localparam int IDX_CMD  = 0;
  localparam int IDX_SCNT = 1;
  localparam int IDX_SADR = 2;
  localparam int IDX_WCNT = 3;
  localparam int IDX_WADR = 4;
  localparam int IDX_STAT = 5;
  localparam int IDX_SLST = 6;
  localparam int IDX_WLST = 7;

  localparam int CMD_DIR_BIT = 7;
  localparam int ST_W        = 6;
  localparam int ST_DONE     = 3;
  localparam int ST_IRQ      = 4;

  localparam logic [ST_W-1:0] ST_STICKY = 6'b001110;

  function automatic logic [63:0] clip_len(input logic [63:0] want,
                                           input logic [63:0] avail);
    return (want < avail) ? want : avail;
  endfunction

  function automatic logic [ST_W-1:0] sticky_clear(input logic [ST_W-1:0] cur,
                                                   input logic [ST_W-1:0] hits);
    return cur & ~(hits & ST_STICKY);
  endfunction

endpackage

// File: rtl/dmachan_cmd_dec.sv
module dmachan_cmd_dec
  import dmachan_pkg::*;
(
  input  logic       wr_cmd,
  input  logic [1:0] act_field,
  output logic       go_idle,
  output logic       go_abort,
  output logic       go_start
);
  dma_act_e act;
  assign act      = dma_act_e'(act_field);
  assign go_idle  = wr_cmd && (act == ACT_IDLE);
  assign go_abort = wr_cmd && (act == ACT_ABORT);
  assign go_start = wr_cmd && (act == ACT_START);
endmodule

// File: rtl/dmachan_xfer.sv
module dmachan_xfer
  import dmachan_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          req,
  input  logic          to_mem,
  input  logic          cmd_to_mem,
  input  logic [LW-1:0] want,
  input  logic [DW-1:0] wcnt,
  input  logic [DW-1:0] wadr,
  output logic          ack,
  output logic [LW-1:0] grant,
  output logic [DW-1:0] wcnt_nxt,
  output logic [DW-1:0] wadr_nxt,
  output logic          hit_zero
);
  logic [63:0] clipped;

  assign ack      = req && (to_mem == cmd_to_mem);
  assign clipped  = clip_len(64'(want), 64'(wcnt));
  assign grant    = ack ? LW'(clipped) : '0;
  assign wcnt_nxt = wcnt - DW'(grant);
  assign wadr_nxt = wadr + DW'(grant);
  assign hit_zero = (wcnt_nxt == '0);
endmodule

// File: rtl/dmachan_regs.sv
module dmachan_regs
  import dmachan_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [2:0]    host_idx,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          st_w1c_mode,
  input  logic          core_irq,
  input  logic          chunk_req,
  input  logic          chunk_to_mem,
  input  logic [LW-1:0] chunk_len,
  output logic          chunk_ack,
  output logic [LW-1:0] chunk_grant,
  input  logic          req_complete,
  output logic          dma_run,
  output logic          abort_req
);
  localparam logic [DW-1:0] WADR_RST = '1;
  localparam logic [DW-1:0] WLST_RST = ~DW'(2);

  logic [DW-1:0]   cmd_q, scnt_q, sadr_q, wcnt_q, wadr_q, slst_q, wlst_q;
  logic [ST_W-1:0] stat_q;

  logic            wr_cmd, stat_wr, stat_rd;
  logic            idle_evt, abort_evt, start_evt;
  logic [DW-1:0]   wcnt_nxt, wadr_nxt;
  logic            hit_zero;
  logic [ST_W-1:0] stat_view;

  assign wr_cmd  = host_wr && (host_idx == 3'(IDX_CMD));
  assign stat_wr = host_wr && (host_idx == 3'(IDX_STAT));
  assign stat_rd = host_rd && (host_idx == 3'(IDX_STAT));

  dmachan_cmd_dec u_dec (
    .wr_cmd   (wr_cmd),
    .act_field(host_wdata[1:0]),
    .go_idle  (idle_evt),
    .go_abort (abort_evt),
    .go_start (start_evt)
  );

  dmachan_xfer #(.DW(DW), .LW(LW)) u_xfer (
    .req       (chunk_req),
    .to_mem    (chunk_to_mem),
    .cmd_to_mem(cmd_q[CMD_DIR_BIT]),
    .want      (chunk_len),
    .wcnt      (wcnt_q),
    .wadr      (wadr_q),
    .ack       (chunk_ack),
    .grant     (chunk_grant),
    .wcnt_nxt  (wcnt_nxt),
    .wadr_nxt  (wadr_nxt),
    .hit_zero  (hit_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      scnt_q    <= '0;
      sadr_q    <= '0;
      wcnt_q    <= '0;
      wadr_q    <= WADR_RST;
      slst_q    <= '0;
      wlst_q    <= WLST_RST;
      stat_q    <= '0;
      dma_run   <= 1'b0;
      abort_req <= 1'b0;
    end else begin
      abort_req <= abort_evt;
      if (host_wr) begin
        case (host_idx)
          3'(IDX_CMD):  cmd_q  <= host_wdata;
          3'(IDX_SCNT): scnt_q <= host_wdata;
          3'(IDX_SADR): sadr_q <= host_wdata;
          3'(IDX_SLST): slst_q <= host_wdata;
          default: ;
        endcase
      end
      if (idle_evt) dma_run <= 1'b0;
      if (start_evt) begin
        wcnt_q  <= scnt_q;
        wadr_q  <= sadr_q;
        wlst_q  <= slst_q;
        stat_q  <= '0;
        dma_run <= 1'b1;
      end
      if (stat_wr && st_w1c_mode)
        stat_q <= sticky_clear(stat_q, host_wdata[ST_W-1:0]);
      if (stat_rd && !st_w1c_mode)
        stat_q <= sticky_clear(stat_q, '1);
      if (chunk_ack) begin
        wcnt_q <= wcnt_nxt;
        wadr_q <= wadr_nxt;
        if (hit_zero) stat_q[ST_DONE] <= 1'b1;
      end
      if (req_complete) begin
        wcnt_q          <= '0;
        stat_q[ST_DONE] <= 1'b1;
      end
    end
  end

  always_comb begin
    stat_view         = stat_q;
    stat_view[ST_IRQ] = stat_q[ST_IRQ] | core_irq;
  end

  always_comb begin
    case (host_idx)
      3'(IDX_CMD):  host_rdata = cmd_q;
      3'(IDX_SCNT): host_rdata = scnt_q;
      3'(IDX_SADR): host_rdata = sadr_q;
      3'(IDX_WCNT): host_rdata = wcnt_q;
      3'(IDX_WADR): host_rdata = wadr_q;
      3'(IDX_STAT): host_rdata = DW'(stat_view);
      3'(IDX_SLST): host_rdata = slst_q;
      default:      host_rdata = wlst_q;
    endcase
  end

endmodule

// File: rtl/dmachan_regs_chk.sv
module dmachan_regs_chk #(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr,
  input logic          host_rd,
  input logic [2:0]    host_idx,
  input logic          st_w1c_mode,
  input logic          chunk_req,
  input logic          chunk_to_mem,
  input logic          chunk_ack,
  input logic [LW-1:0] chunk_grant,
  input logic          req_complete,
  input logic          dma_run,
  input logic          abort_req,
  input logic [DW-1:0] cmd_q,
  input logic [DW-1:0] scnt_q,
  input logic [DW-1:0] wcnt_q,
  input logic [DW-1:0] wadr_q,
  input logic [5:0]    stat_q,
  input logic          start_evt,
  input logic          abort_evt
);

  p_start_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && !chunk_req && !req_complete |=>
      (wcnt_q == $past(scnt_q)) && dma_run && (stat_q == '0));

  p_abort_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> abort_req);

  p_chunk_math_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_ack && !start_evt && !req_complete |=>
      (wcnt_q == $past(wcnt_q) - DW'($past(chunk_grant))) &&
      (wadr_q == $past(wadr_q) + DW'($past(chunk_grant))));

  p_grant_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_ack |-> DW'(chunk_grant) <= wcnt_q);

  p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_ack && (DW'(chunk_grant) == wcnt_q) && !start_evt |=> stat_q[3]);

  p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_req && (chunk_to_mem != cmd_q[7]) && !host_wr && !req_complete |=>
      $stable(wcnt_q) && $stable(wadr_q));

  p_status_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && (host_idx == 3'd5) && !st_w1c_mode && !host_rd &&
    !chunk_req && !req_complete |=> $stable(stat_q));

  p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && (host_idx == 3'd5) && !st_w1c_mode && !host_wr &&
    !chunk_req && !req_complete |=> (stat_q & 6'b001110) == '0);

  p_complete_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_complete |=> (wcnt_q == '0) && stat_q[3]);

endmodule

bind dmachan_regs dmachan_regs_chk #(.DW(DW), .LW(LW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_idx    (host_idx),
  .st_w1c_mode (st_w1c_mode),
  .chunk_req   (chunk_req),
  .chunk_to_mem(chunk_to_mem),
  .chunk_ack   (chunk_ack),
  .chunk_grant (chunk_grant),
  .req_complete(req_complete),
  .dma_run     (dma_run),
  .abort_req   (abort_req),
  .cmd_q       (cmd_q),
  .scnt_q      (scnt_q),
  .wcnt_q      (wcnt_q),
  .wadr_q      (wadr_q),
  .stat_q      (stat_q),
  .start_evt   (start_evt),
  .abort_evt   (abort_evt)
);

// File: tb/dmachan_regs_test.sv
module dmachan_regs_test;
  localparam int DW = 32;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]    host_idx = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          st_w1c_mode = 1'b0, core_irq = 1'b0;
  logic          chunk_req = 1'b0, chunk_to_mem = 1'b0;
  logic [LW-1:0] chunk_len = '0;
  logic          chunk_ack;
  logic [LW-1:0] chunk_grant;
  logic          req_complete = 1'b0;
  logic          dma_run, abort_req;

  always #10 clk = ~clk;

  dmachan_regs #(.DW(DW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .st_w1c_mode(st_w1c_mode), .core_irq(core_irq),
    .chunk_req(chunk_req), .chunk_to_mem(chunk_to_mem), .chunk_len(chunk_len),
    .chunk_ack(chunk_ack), .chunk_grant(chunk_grant),
    .req_complete(req_complete), .dma_run(dma_run), .abort_req(abort_req)
  );

  // kind: 0 read data, 1 dma_run, 2 abort_req, 3 chunk_ack, 4 chunk_grant
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t queue_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 0;

  always @(negedge clk) begin
    while (queue_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = queue_q.pop_front();
      case (it.kind)
        0:       act = host_rdata;
        1:       act = 32'(dma_run);
        2:       act = 32'(abort_req);
        3:       act = 32'(chunk_ack);
        default: act = 32'(chunk_grant);
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind %0d: actual 0x%08h expected 0x%08h",
                 it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    queue_q.push_back(it);
  endtask

  task automatic idle_all();
    host_wr = 0; host_rd = 0; chunk_req = 0; req_complete = 0;
  endtask

  task automatic rd(input int idx, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    host_rd = 1; host_idx = 3'(idx);
    push(0, exp, tag);
    @(posedge clk); #1;
    idle_all();
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(posedge clk); #1;
    host_wr = 1; host_idx = 3'(idx); host_wdata = d;
    @(posedge clk); #1;
    idle_all();
  endtask

  task automatic chunk(input bit to_mem, input int len, input bit exp_ack,
                       input int exp_grant, input string tag);
    @(posedge clk); #1;
    chunk_req = 1; chunk_to_mem = to_mem; chunk_len = LW'(len);
    push(3, 32'(exp_ack), tag);
    push(4, 32'(exp_grant), tag);
    @(posedge clk); #1;
    idle_all();
  endtask

  task automatic complete();
    @(posedge clk); #1;
    req_complete = 1;
    @(posedge clk); #1;
    idle_all();
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset values
    push(1, 0, "R1 run"); push(2, 0, "R1 abort");
    rd(0, 32'h0, "R1 cmd");
    rd(1, 32'h0, "R1 scnt");
    rd(2, 32'h0, "R1 sadr");
    rd(3, 32'h0, "R1 wcnt");
    rd(4, 32'hFFFF_FFFF, "R1 wadr");
    rd(5, 32'h0, "R1 stat");
    rd(6, 32'h0, "R1 slst");
    rd(7, 32'hFFFF_FFFD, "R1 wlst");
    // R2 map
    wr(1, 32'h100); wr(2, 32'h8000_0000); wr(6, 32'h1234);
    wr(3, 32'h5); wr(4, 32'h5); wr(7, 32'h5);
    rd(1, 32'h100, "R2 scnt");
    rd(2, 32'h8000_0000, "R2 sadr");
    rd(6, 32'h1234, "R2 slst");
    rd(3, 32'h0, "R2 wcnt ignored");
    rd(4, 32'hFFFF_FFFF, "R2 wadr ignored");
    rd(7, 32'hFFFF_FFFD, "R2 wlst ignored");
    // R3 start, device to memory
    wr(0, 32'h83);
    push(1, 1, "R3 run after start");
    rd(0, 32'h83, "R3 cmd readback");
    rd(3, 32'h100, "R3 wcnt copy");
    rd(4, 32'h8000_0000, "R3 wadr copy");
    rd(7, 32'h1234, "R3 wlst copy");
    // R7 reject
    chunk(0, 16, 0, 0, "R7 reject");
    rd(3, 32'h100, "R7 wcnt kept");
    rd(4, 32'h8000_0000, "R7 wadr kept");
    // R5 chunk
    chunk(1, 32'h40, 1, 32'h40, "R5 chunk");
    rd(3, 32'hC0, "R5 wcnt");
    rd(4, 32'h8000_0040, "R5 wadr");
    rd(5, 32'h0, "R6 not done yet");
    // R6 clipped chunk ends count
    chunk(1, 32'h200, 1, 32'hC0, "R5 clip");
    rd(3, 32'h0, "R6 wcnt zero");
    rd(4, 32'h8000_0100, "R5 wadr end");
    st_w1c_mode = 1;
    rd(5, 32'h8, "R6 done");
    rd(5, 32'h8, "R8 no clear on read");
    // R8 write-one-to-clear
    wr(5, 32'h30);
    rd(5, 32'h8, "R8 other bits");
    wr(5, 32'h08);
    rd(5, 32'h0, "R8 done cleared");
    // R11 core interrupt
    core_irq = 1;
    rd(5, 32'h10, "R11 irq shown");
    core_irq = 0;
    rd(5, 32'h0, "R11 irq gone");
    // R12 completion and R3 status wipe on start
    complete();
    rd(5, 32'h8, "R12 done");
    wr(0, 32'h83);
    rd(5, 32'h0, "R3 status cleared");
    rd(3, 32'h100, "R3 recopy");
    complete();
    rd(3, 32'h0, "R12 wcnt zero");
    rd(5, 32'h8, "R12 done again");
    // R9 / R10 read-clear mode
    st_w1c_mode = 0;
    wr(5, 32'hFF);
    rd(5, 32'h8, "R9 write ignored");
    rd(5, 32'h0, "R10 read cleared");
    // R4 abort and blast
    wr(0, 32'h02);
    push(2, 1, "R4 abort pulse");
    push(1, 1, "R4 run kept");
    @(posedge clk); #1;
    push(2, 0, "R4 pulse one cycle");
    wr(0, 32'h01);
    push(2, 0, "R4 blast no abort");
    push(1, 1, "R4 blast run kept");
    rd(0, 32'h01, "R4 blast stored");
    // R3 idle
    wr(0, 32'h00);
    push(1, 0, "R3 idle stops");
    // R5 other direction
    wr(0, 32'h03);
    chunk(0, 5, 1, 5, "R5 to device");
    chunk(1, 5, 0, 0, "R7 wrong dir");
    rd(3, 32'hFB, "R5 wcnt to device");
    rd(4, 32'h8000_0005, "R5 wadr to device");
    @(posedge clk); #1;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule